// File: doc/BRIEF.md
# Decimating Multichannel Tap History Sequencer

This block keeps a sample history for each of several channels in one shared tap store, and a set of binary coefficient sequences in a coefficient store. Both stores are cut into equal power-of-two sections: one section per channel in the tap store, and one per sequence in the coefficient store. Samples arrive tagged with a channel number. Each channel has its own circular write pointer, and a channel keeps `OSF*NTAP` samples of history.

When a correlation is requested for a channel and a coefficient sequence, the block streams one beat per coefficient slot to a downstream correlator. There are `CSEC` beats, where `CSEC` is `NTAP` rounded up to a power of two. The beats run from the most significant slot down to slot 0. The slots above `NTAP-1` are zero padding and come first. Each real slot `k` pairs coefficient bit `k` with the sample written `1 + k*OSF` writes ago on that channel. Slot 0 therefore carries the newest sample, and the slots above it carry every `OSF`-th older sample. This decimates oversampled input.

While a stream runs, sample writes to that same channel are held off so that its history cannot change mid-correlation. Writes to other channels proceed as normal.

Top module: `corr_tap_seq`

## Requirements
- R1: After reset, `rd_vld` is 0, `req_rdy` and `smp_rdy` are 1, and every history position and every coefficient bit reads as 0.
- R2: A request accepted at a clock edge (`req_vld` and `req_rdy` both high) produces exactly `CSEC` consecutive beats with `rd_vld` high, starting in the cycle after that edge. `rd_start` is high only on the first beat and `rd_last` only on the final beat, and `rd_vld` is low in the cycle after the final beat.
- R3: `req_rdy` is low while a stream is running, and a request presented then is ignored.
- R4: Each channel has its own circular write pointer. An accepted sample is stored at that channel's pointer, and then that pointer alone advances by one, wrapping within the channel's section.
- R5: The beat for real slot `k` (`0 <= k < NTAP`) carries on `rd_tap` the sample written to the requested channel `1 + k*OSF` writes earlier. If fewer writes than that have been made since reset, `rd_tap` is 0.
- R6: Beat `j` (counted from 0) serves slot `CSEC-1-j`. The first `CSEC-NTAP` beats are padding, and the final beat is slot 0, which carries the newest sample.
- R7: Padding beats present `rd_tap` = 0 and `rd_coef` = 0. Coefficient writes with `cf_idx >= NTAP` are ignored.
- R8: On the beat for real slot `k`, `rd_coef` equals the last bit written to index `k` of the requested sequence. Sequences do not affect one another.
- R9: Sample writes to one channel never change the history that another channel presents.
- R10: During a stream, `smp_rdy` is low whenever `smp_ch` equals the channel being read, and such a write is dropped. Writes to any other channel are accepted in the same period.
- R11: History stays correct after a channel's pointer has wrapped its section several times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_vld | input | 1 | Sample write strobe |
| smp_ch | input | CHW | Channel of the sample |
| smp_data | input | DW | Sample value |
| smp_rdy | output | 1 | Sample write is accepted this cycle |
| cf_vld | input | 1 | Coefficient write strobe |
| cf_seq | input | SW | Coefficient sequence to write |
| cf_idx | input | CW | Slot index within the sequence |
| cf_bit | input | 1 | Coefficient bit value |
| req_vld | input | 1 | Correlation request |
| req_ch | input | CHW | Channel to correlate |
| req_seq | input | SW | Coefficient sequence to use |
| req_rdy | output | 1 | Request is accepted this cycle |
| rd_vld | output | 1 | Stream beat valid |
| rd_start | output | 1 | First beat of a stream |
| rd_last | output | 1 | Final beat of a stream |
| rd_tap | output | DW | History sample for this slot |
| rd_coef | output | 1 | Coefficient bit for this slot |

## Verification
The sample pattern gives each channel its own arithmetic ramp, so a tap read from the wrong channel, the wrong age or the wrong decimation stride yields a visibly different value. Correlations are run before any write, then after partial fills, and again after the pointers have wrapped. These three points separate the zero-history, short-history and wrapped cases. Every channel is paired with every coefficient sequence, and the two sequences carry distinct bit patterns, so a swapped sequence or a reversed slot order is exposed. One stream is run while the same channel is written, another channel is written, and a second request is presented. This shows that only the same-channel write and the extra request are dropped.

// File: rtl/corr_tap_seq.sv
module corr_tap_seq #(
  parameter int DW   = 4,
  parameter int NTAP = 6,
  parameter int OSF  = 2,
  parameter int NCH  = 2,
  parameter int NSEQ = 2,
  localparam int HIST = OSF * NTAP,
  localparam int AW   = (HIST > 1) ? $clog2(HIST) : 1,
  localparam int TSEC = 1 << AW,
  localparam int CW   = (NTAP > 1) ? $clog2(NTAP) : 1,
  localparam int CSEC = 1 << CW,
  localparam int CHW  = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int SW   = (NSEQ > 1) ? $clog2(NSEQ) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           smp_vld,
  input  logic [CHW-1:0] smp_ch,
  input  logic [DW-1:0]  smp_data,
  output logic           smp_rdy,
  input  logic           cf_vld,
  input  logic [SW-1:0]  cf_seq,
  input  logic [CW-1:0]  cf_idx,
  input  logic           cf_bit,
  input  logic           req_vld,
  input  logic [CHW-1:0] req_ch,
  input  logic [SW-1:0]  req_seq,
  output logic           req_rdy,
  output logic           rd_vld,
  output logic           rd_start,
  output logic           rd_last,
  output logic [DW-1:0]  rd_tap,
  output logic           rd_coef
);

  logic [DW-1:0]   tmem [NCH*TSEC];
  logic [AW-1:0]   wp   [NCH];
  logic [CSEC-1:0] cmem [NSEQ];
  logic            busy;
  logic [CW-1:0]   beat;
  logic [CHW-1:0]  cur_ch;
  logic [SW-1:0]   cur_seq;

  logic [CW-1:0] pos;
  logic          pad;
  logic [AW-1:0] back, off;
  logic          smp_go;

  assign pos  = CW'(CSEC - 1) - beat;
  assign pad  = 32'(pos) >= 32'(NTAP);
  assign back = AW'(32'd1 + 32'(pos) * 32'(OSF));
  assign off  = wp[cur_ch] - back;

  assign rd_vld   = busy;
  assign rd_start = busy && (beat == '0);
  assign rd_last  = busy && (beat == CW'(CSEC - 1));
  assign rd_tap   = (busy && !pad) ? tmem[{cur_ch, off}] : '0;
  assign rd_coef  = busy && cmem[cur_seq][pos];
  assign req_rdy  = !busy;
  assign smp_rdy  = !(busy && (smp_ch == cur_ch));
  assign smp_go   = smp_vld && smp_rdy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      beat    <= '0;
      cur_ch  <= '0;
      cur_seq <= '0;
      for (int i = 0; i < NCH*TSEC; i++) tmem[i] <= '0;
      for (int i = 0; i < NCH; i++)      wp[i]   <= '0;
      for (int i = 0; i < NSEQ; i++)     cmem[i] <= '0;
    end else begin
      if (smp_go) begin
        tmem[{smp_ch, wp[smp_ch]}] <= smp_data;
        wp[smp_ch] <= wp[smp_ch] + 1'b1;
      end
      if (cf_vld && (32'(cf_idx) < 32'(NTAP)))
        cmem[cf_seq][cf_idx] <= cf_bit;
      if (busy) begin
        beat <= beat + 1'b1;
        if (rd_last) busy <= 1'b0;
      end else if (req_vld) begin
        busy    <= 1'b1;
        beat    <= '0;
        cur_ch  <= req_ch;
        cur_seq <= req_seq;
      end
    end
  end

  p_start_after_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && req_rdy) |=> (rd_vld && rd_start));

  p_stream_ends_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_vld && rd_last) |=> !rd_vld);

  p_marks_distinct_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_vld |-> !(rd_start && rd_last));

  p_busy_blocks_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_vld |-> !req_rdy);

  p_pad_coef_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && pad) |-> !rd_coef);

  p_channel_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_vld && !rd_last) |=> $stable(wp[cur_ch]));

endmodule

// File: tb/sim_corr_tap_seq.sv
`timescale 1ns/1ps
module sim_corr_tap_seq;
  localparam int DW = 4, NTAP = 6, OSF = 2, NCH = 2, NSEQ = 2;
  localparam int CSEC = 8;

  logic clk = 0, rst_n = 0;
  logic smp_vld = 0, cf_vld = 0, cf_bit = 0, req_vld = 0;
  logic [0:0] smp_ch = 0, cf_seq = 0, req_ch = 0, req_seq = 0;
  logic [DW-1:0] smp_data = 0;
  logic [2:0] cf_idx = 0;
  logic smp_rdy, req_rdy, rd_vld, rd_start, rd_last, rd_coef;
  logic [DW-1:0] rd_tap;

  int checks = 0, fails = 0;
  int hist [NCH][512];
  int cnt [NCH];
  int cm [NSEQ][CSEC];

  always #2.5 clk = ~clk;

  corr_tap_seq #(.DW(DW), .NTAP(NTAP), .OSF(OSF), .NCH(NCH), .NSEQ(NSEQ)) u0 (
    .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_ch(smp_ch), .smp_data(smp_data),
    .smp_rdy(smp_rdy), .cf_vld(cf_vld), .cf_seq(cf_seq), .cf_idx(cf_idx), .cf_bit(cf_bit),
    .req_vld(req_vld), .req_ch(req_ch), .req_seq(req_seq), .req_rdy(req_rdy),
    .rd_vld(rd_vld), .rd_start(rd_start), .rd_last(rd_last), .rd_tap(rd_tap), .rd_coef(rd_coef));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr_smp(input int ch, input int d);
    @(negedge clk);
    smp_vld = 1; smp_ch = ch[0:0]; smp_data = d[DW-1:0];
    chk(smp_rdy == 1, "R4 smp_rdy idle", smp_rdy, 1);
    @(negedge clk);
    smp_vld = 0;
    hist[ch][cnt[ch]] = d % 16;
    cnt[ch]++;
  endtask

  task automatic wr_cf(input int s, input int idx, input int b);
    @(negedge clk);
    cf_vld = 1; cf_seq = s[0:0]; cf_idx = idx[2:0]; cf_bit = b[0];
    @(negedge clk);
    cf_vld = 0;
    if (idx < NTAP) cm[s][idx] = b;
  endtask

  function automatic int exp_tap(input int ch, input int k);
    int age = 1 + k * OSF;
    if (cnt[ch] < age) return 0;
    return hist[ch][cnt[ch] - age];
  endfunction

  task automatic run_corr(input int ch, input int s, input bit hold);
    int other = 1 - ch;
    @(negedge clk);
    chk(req_rdy == 1, "R3 req_rdy idle", req_rdy, 1);
    req_vld = 1; req_ch = ch[0:0]; req_seq = s[0:0];
    @(negedge clk);
    req_vld = 0;
    for (int j = 0; j < CSEC; j++) begin
      int p = CSEC - 1 - j;
      int et = (p >= NTAP) ? 0 : exp_tap(ch, p);
      int ec = (p >= NTAP) ? 0 : cm[s][p];
      chk(rd_vld == 1, "R2 rd_vld in stream", rd_vld, 1);
      chk(rd_start == (j == 0), "R2 rd_start", rd_start, j == 0);
      chk(rd_last == (j == CSEC - 1), "R2 rd_last", rd_last, j == CSEC - 1);
      if (p >= NTAP) begin
        chk(rd_tap == 0, "R7 pad tap zero", rd_tap, 0);
        chk(rd_coef == 0, "R7 pad coef zero", rd_coef, 0);
      end else begin
        chk(int'(rd_tap) == et, (p == 0) ? "R6 newest on last beat" : "R5 decimated tap", rd_tap, et);
        chk(int'(rd_coef) == ec, "R8 coefficient bit", rd_coef, ec);
      end
      if (hold) begin
        if (j == 1) begin
          smp_vld = 1; smp_ch = ch[0:0]; smp_data = 4'hF;
          req_vld = 1; req_ch = other[0:0]; req_seq = s[0:0];
          #0.1;
          chk(smp_rdy == 0, "R10 same channel held", smp_rdy, 0);
          chk(req_rdy == 0, "R3 req_rdy busy", req_rdy, 0);
        end else if (j == 2) begin
          req_vld = 0;
          smp_vld = 1; smp_ch = other[0:0]; smp_data = 4'h9;
          #0.1;
          chk(smp_rdy == 1, "R10 other channel open", smp_rdy, 1);
          hist[other][cnt[other]] = 9;
          cnt[other]++;
        end else if (j == 3) begin
          smp_vld = 0;
        end
      end
      @(negedge clk);
    end
    chk(rd_vld == 0, hold ? "R3 busy request ignored" : "R2 stream ended", rd_vld, 0);
  endtask

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("%0d/%0d checks passed", checks - fails + 1, checks + 1);
    $finish;
  end

  initial begin
    for (int c = 0; c < NCH; c++) cnt[c] = 0;
    for (int s = 0; s < NSEQ; s++) for (int i = 0; i < CSEC; i++) cm[s][i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(rd_vld == 0, "R1 rd_vld reset", rd_vld, 0);
    chk(req_rdy == 1, "R1 req_rdy reset", req_rdy, 1);
    chk(smp_rdy == 1, "R1 smp_rdy reset", smp_rdy, 1);
    run_corr(0, 0, 0);  // R1 empty history and zero coefficients
    for (int i = 0; i < NTAP; i++) begin
      wr_cf(0, i, (i % 3 == 0) ? 1 : 0);
      wr_cf(1, i, (i % 2 == 1) ? 1 : 0);
    end
    for (int i = NTAP; i < CSEC; i++) wr_cf(0, i, 1);  // R7 pad writes dropped
    for (int r = 0; r < 3; r++) begin
      wr_smp(0, r * 3 + 1);
      wr_smp(1, r * 5 + 2);
    end
    for (int c = 0; c < NCH; c++) for (int s = 0; s < NSEQ; s++) run_corr(c, s, 0);
    for (int r = 0; r < 13; r++) wr_smp(0, r * 7 + 3);  // R9 only channel 0 moves
    for (int c = 0; c < NCH; c++) for (int s = 0; s < NSEQ; s++) run_corr(c, s, 0);
    for (int r = 0; r < 50; r++) begin  // R11 several pointer wraps
      wr_smp(0, r * 3 + 5);
      wr_smp(1, r * 11 + 1);
      if (r % 17 == 16) for (int c = 0; c < NCH; c++) run_corr(c, r % 2, 0);
    end
    for (int c = 0; c < NCH; c++) for (int s = 0; s < NSEQ; s++) run_corr(c, s, 0);
    run_corr(0, 1, 1);  // R10 / R3 hold-off during stream
    run_corr(0, 1, 0);
    run_corr(1, 0, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule